// File: doc/BRIEF.md
# GPIO Port with Set and Clear Alias Addresses

This block is a port of general-purpose pins behind a simple memory-mapped register bus. It holds an output-level register and a direction register, and it offers a read-only view of the pad levels. Software writes a pin level into the output-level register and sets the matching direction bit to turn that pin into an output. It reads the pad levels back through the input view.

Each writable register answers at three word addresses. The first replaces the whole value. The second ORs the written word into the register. The third clears each bit that is 1 in the written word. With the two alias addresses, one pin can be changed in a single bus write, and the other pins are not touched. Without them, software would need a read-modify-write sequence that can race with other agents. The pad levels pass through a two-flop synchroniser before they can be read.

Top module: `gpio_alias_port`

## Requirements
- R1: After a synchronous active-low reset, the output-level and direction registers are all zero. `pad_oe` and `pad_out` are then all zero, and the input view reads zero.
- R2: Register groups sit at 16-byte strides: output level at 0x00, direction at 0x10, input view at 0x20. A write at offset 0x0 of a group replaces the whole register with `bus_wdata`.
- R3: A write at offset 0x4 of a writable group ORs `bus_wdata` into the register. Bits that are 0 in the data keep their value.
- R4: A write at offset 0x8 of a writable group clears each register bit whose `bus_wdata` bit is 1. The other bits keep their value.
- R5: `bus_rdata` is combinational from `bus_addr`. Reads at offsets 0x0, 0x4 and 0x8 of a group all return that register's current value.
- R6: The input view is read-only. A write anywhere in the 0x20 group leaves both writable registers and both pad output vectors unchanged.
- R7: A change on `pad_in` first shows in the input view after exactly two rising clock edges. After one edge the view still holds the old level.
- R8: `pad_oe` equals the direction register, where a 1 bit makes the pin an output. `pad_out` equals the output level ANDed with the direction, so a pin is driven high only while it is an output.
- R9: Unmapped addresses give 0 on read and change no state on write. These are offset 0xC of any group, the 0x30 group, and any address with either of its two low bits set.
- R10: A register write takes effect at the rising edge where `bus_sel` and `bus_wr` are sampled high. The pad vectors change right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address of the access |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Read data for `bus_addr`, combinational |
| pad_in | input | PINS (32) | Asynchronous pad levels |
| pad_out | output | PINS (32) | Level driven towards the pads |
| pad_oe | output | PINS (32) | Per-pin output enable, 1 = output |

## Verification
The bench first walks a single one through every pin using the set alias, then walks a single zero using the clear alias. These two sweeps show whether set and clear reach exactly one bit and leave its neighbours alone. Pseudo-random words then go through all three write flavours to both registers, with all three read aliases compared after each write. This separates replace, OR and clear-mask behaviour and shows any error in the alias decode. Pad input steps are sampled one edge and two edges after they change, which pins down the synchroniser latency. Writes to the input group and to every unmapped address are each followed by readback and a pad comparison, which shows that none of them reached stored state.

// File: rtl/gpio_alias_pkg.sv
// Shared encodings for the alias GPIO port.
// Assumes word-aligned accesses; offsets within a 16-byte group pick the op.
package gpio_alias_pkg;
    // Operation selected by bits [3:2] of the address
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_SET     = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_NONE    = 2'd3
    } alias_op_e;

    // Register group selected by bits [5:4] of the address
    typedef enum logic [1:0] {
        GRP_LEVEL = 2'd0,
        GRP_DIR   = 2'd1,
        GRP_VIEW  = 2'd2,
        GRP_NONE  = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/gpio_alias_decode.sv
// Address decoder: splits a byte address into a register group and an alias op.
// Assumes ADDR_W >= 6; misaligned or out-of-range addresses map to GRP_NONE.
module gpio_alias_decode
    import gpio_alias_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_grp_e          grp,
    output alias_op_e         op
);
    logic upper_zero;

    // Bits above the group field must be zero for a hit
    generate
        if (ADDR_W > 6) begin : g_upper
            assign upper_zero = ~|addr[ADDR_W-1:6];
        end else begin : g_noupper
            assign upper_zero = 1'b1;
        end
    endgenerate

    // Combine alignment, range and field decode into group and op
    always_comb begin
        if (!upper_zero || (addr[1:0] != 2'b00) || (addr[3:2] == 2'd3)) begin
            grp = GRP_NONE;
            op  = OP_NONE;
        end else begin
            grp = reg_grp_e'(addr[5:4]);
            op  = alias_op_e'(addr[3:2]);
        end
    end
endmodule

// File: rtl/gpio_alias_reg.sv
// One writable register with replace, set-alias and clear-alias write flavours.
// Assumes the caller raises we only for a decoded hit on this register.
module gpio_alias_reg
    import gpio_alias_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  alias_op_e       op,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] q
);
    // Apply the selected write flavour, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            case (op)
                OP_REPLACE: q <= wdata;
                OP_SET:     q <= q | wdata;
                OP_CLEAR:   q <= q & ~wdata;
                default:    q <= q;
            endcase
        end
    end

    // R2
    replace_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_REPLACE) |=> (q == $past(wdata)));
    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_SET) |=> (((q & $past(wdata)) == $past(wdata)) &&
                                  ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
    // R4
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLEAR) |=> (((q & $past(wdata)) == '0) &&
                                    ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/gpio_alias_sync.sv
// Two-flop synchroniser bank for the pad inputs.
// Assumes each pad bit is independent; no multi-bit coherence is provided.
module gpio_alias_sync #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);
    logic [PINS-1:0] stage1;
    logic [1:0]      settled;

    // Shift pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

    // Count edges since reset so the latency check only looks at valid history
    always_ff @(posedge clk) begin
        if (!rst_n)              settled <= 2'd0;
        else if (settled != 2'd2) settled <= settled + 2'd1;
    end

    // R7
    two_edge_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_alias_port.sv
// GPIO port top: bus decode, two alias registers, pad synchroniser and readback.
// Assumes single-cycle bus writes and a combinational read path from the address.
module gpio_alias_port
    import gpio_alias_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    localparam int NUM_WREGS = 2;

    reg_grp_e        grp;
    alias_op_e       op;
    logic [PINS-1:0] wreg_q [NUM_WREGS];
    logic [PINS-1:0] view_q;
    logic [PINS-1:0] level_q;
    logic [PINS-1:0] dir_q;

    gpio_alias_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .grp  (grp),
        .op   (op)
    );

    // One alias register per writable group: index 0 level, index 1 direction
    generate
        for (genvar g = 0; g < NUM_WREGS; g++) begin : g_wreg
            logic hit;
            assign hit = bus_sel && bus_wr && (op != OP_NONE) &&
                         (grp == ((g == 0) ? GRP_LEVEL : GRP_DIR));
            gpio_alias_reg #(.PINS(PINS)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (hit),
                .op    (op),
                .wdata (bus_wdata),
                .q     (wreg_q[g])
            );
        end
    endgenerate

    assign level_q = wreg_q[0];
    assign dir_q   = wreg_q[1];

    gpio_alias_sync #(.PINS(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (view_q)
    );

    // Pad drive: enable follows direction, level only where the pin is an output
    assign pad_oe  = dir_q;
    assign pad_out = level_q & dir_q;

    // Readback mux; every alias of a group returns the same register
    always_comb begin
        case (grp)
            GRP_LEVEL: bus_rdata = level_q;
            GRP_DIR:   bus_rdata = dir_q;
            GRP_VIEW:  bus_rdata = view_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R6
    view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[5:4] == 2'd2) |=> ($stable(pad_oe) && $stable(pad_out)));
    // R9
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr[5:4] == 2'd3 || bus_addr[1:0] != 2'd0))
        |=> ($stable(pad_oe) && $stable(pad_out)));
    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:4] == 2'd3) |-> (bus_rdata == '0));
    // R10
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/gpio_alias_port_test.sv
module gpio_alias_port_test;
    localparam int PINS = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [PINS-1:0] bus_wdata = '0;
    logic [PINS-1:0] bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out;
    logic [PINS-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    logic [PINS-1:0] m_level = '0;
    logic [PINS-1:0] m_dir = '0;
    logic [PINS-1:0] lfsr = 32'h1ACE_B00C;

    gpio_alias_port #(.PINS(PINS), .ADDR_W(6)) uut (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
        .bus_rdata, .pad_in, .pad_out, .pad_oe
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [PINS-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [PINS-1:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Update the bench model for a write to group g (0 level, 1 direction) with op o
    function automatic logic [PINS-1:0] apply(input logic [PINS-1:0] cur, input int o, input logic [PINS-1:0] d);
        case (o)
            0: return d;
            1: return cur | d;
            2: return cur & ~d;
            default: return cur;
        endcase
    endfunction

    task automatic model_write(input int g, input int o, input logic [PINS-1:0] d);
        bus_write(6'((g << 4) | (o << 2)), d);
        if (g == 0) m_level = apply(m_level, o, d);
        else if (g == 1) m_dir = apply(m_dir, o, d);
    endtask

    task automatic check_all(input string tag);
        logic [PINS-1:0] r;
        for (int o = 0; o < 3; o++) begin
            bus_read(6'(o << 2), r);        check({tag, " R5 level"}, r, m_level);
            bus_read(6'(16 | (o << 2)), r); check({tag, " R5 dir"}, r, m_dir);
        end
        check({tag, " R8 pad_oe"}, pad_oe, m_dir);
        check({tag, " R8 pad_out"}, pad_out, m_level & m_dir);
    endtask

    function automatic logic [PINS-1:0] step(input logic [PINS-1:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        logic [PINS-1:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(6'h00, r); check("R1 level", r, '0);
        bus_read(6'h10, r); check("R1 dir", r, '0);
        bus_read(6'h20, r); check("R1 view", r, '0);

        // R3: walking one via set alias on both registers
        for (int i = 0; i < PINS; i++) begin
            model_write(0, 1, PINS'(1) << i);
            model_write(1, 1, PINS'(1) << (PINS - 1 - i));
            check_all("R3 walk-set");
        end
        // R4: walking zero via clear alias
        for (int i = 0; i < PINS; i++) begin
            model_write(0, 2, PINS'(1) << i);
            check_all("R4 walk-clear");
            model_write(0, 1, PINS'(1) << i);
        end
        model_write(1, 2, '1);
        check_all("R4 clear-all");

        // R2 R3 R4: pseudo-random mix of flavours and registers
        for (int n = 0; n < 60; n++) begin
            lfsr = step(lfsr);
            model_write(int'(lfsr[0]), n % 3, step(lfsr) ^ {lfsr[15:0], lfsr[31:16]});
            check_all("R2 mix");
        end

        // R10: change appears after the write edge, not before it
        model_write(0, 0, 32'hFFFF_0000);
        model_write(1, 0, 32'h0000_0000);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h00FF_FF00;
        #1 check("R10 before edge", pad_oe, 32'h0);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        m_dir = 32'h00FF_FF00;
        check("R10 after edge oe", pad_oe, m_dir);
        check("R10 after edge out", pad_out, 32'h00FF_0000);

        // R6: writes to the input view group change nothing
        for (int o = 0; o < 4; o++) begin
            bus_write(6'(32 | (o << 2)), 32'hDEAD_BEEF);
            check_all("R6 view write");
        end

        // R9: unmapped addresses
        bus_write(6'h0C, '1); check_all("R9 off-C level");
        bus_write(6'h1C, '1); check_all("R9 off-C dir");
        bus_write(6'h01, '1); check_all("R9 misaligned");
        bus_write(6'h12, '0); check_all("R9 misaligned dir");
        for (int a = 48; a < 64; a += 4) begin
            bus_write(6'(a), '1);
            check_all("R9 upper group");
            bus_read(6'(a), r); check("R9 read zero", r, '0);
        end
        bus_read(6'h0C, r); check("R9 read off-C", r, '0);
        bus_read(6'h05, r); check("R9 read misaligned", r, '0);

        // R7: synchroniser latency, one edge then two
        for (int i = 0; i < 8; i++) begin
            logic [PINS-1:0] prev;
            logic [PINS-1:0] nxt;
            lfsr = step(lfsr);
            prev = pad_in;
            nxt = lfsr;
            @(negedge clk);
            pad_in = nxt;
            @(negedge clk);
            bus_read(6'h20, r); check("R7 one edge", r, prev);
            @(negedge clk);
            bus_read(6'h24, r); check("R7 two edges", r, nxt);
            bus_read(6'h28, r); check("R7 alias read", r, nxt);
        end

        // R1: reset again clears registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_level = '0; m_dir = '0;
        check_all("R1 re-reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule